// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel

This block is a single DMA channel that runs a list of command descriptors held in memory. Software places descriptors in memory, loads a semaphore count and pulses a start input with the address of the first descriptor. For each descriptor the channel reads a three-word header through a 32-bit memory master port. It then writes up to sixteen programmed I/O words to numbered peripheral register slots. After that it moves a word-counted buffer between memory and a 32-bit peripheral data port, in the direction the command selects.

Descriptors link through a next-pointer word. A chained descriptor is followed only while the semaphore is nonzero. A descriptor may decrement the semaphore when it finishes, so a ring of linked descriptors runs for as long as software keeps adding to the count. When the additions stop, the ring parks cleanly. The channel exposes the current buffer address, a one-cycle completion pulse and an error cause. It also has a freeze input that holds progress at the next word boundary.

Top module: `dmac_channel`

## Requirements
- R1: After reset `busy`, `irq`, `mem_req`, `per_req` and `pio_we` are 0, and `err_cause` and `sema_cnt` are 0.
- R2: Descriptor layout at byte address P: P holds the next pointer, P+4 holds the control word in [15:0] and the byte count in [31:16], P+8 holds the buffer address, and P+12 onward holds the PIO words. Control bits: [1:0] command, 2 chain, 3 interrupt, 6 semaphore decrement, 7 wait for end, 8 halt on terminate, [15:12] PIO word count. Bits 4, 5, 9, 10 and 11 are ignored.
- R3: A PIO count of N writes the words at P+12, P+16, … to `pio_sel` 0 … N-1 in order. Each write is one `pio_we` strobe, and all of them come before any data word of the same descriptor.
- R4: Command 2 reads ceil(count/4) words from memory at successive addresses starting at the buffer address and writes each one to the peripheral. Command 1 reads words from the peripheral and writes them to memory the same way. Commands 0 and 3 move no data.
- R5: When a descriptor ends, `irq` pulses for one cycle only if bit 3 is set, and the semaphore drops by one only if bit 6 is set. `sema_add` adds its value to the semaphore each cycle.
- R6: If bit 2 is set, the channel fetches the descriptor at the next pointer, but only while `sema_cnt` is nonzero, and otherwise waits with `busy` high. If bit 2 is clear, the channel returns to idle. A start also waits for a nonzero semaphore.
- R7: A ring of chained, decrementing descriptors runs one descriptor per semaphore unit and then waits without error. Adding to the semaphore resumes it at the descriptor where it stopped.
- R8: `cur_addr` equals the buffer address plus 4 times the number of words moved in the current descriptor.
- R9: `per_term` during a data phase with bit 8 set ends the descriptor and halts the channel with `err_cause` = 1 (termination). If `per_term` coincides with the completion of the last word, the descriptor finishes normally. With bit 8 clear, `per_term` is ignored.
- R10: A memory response with `mem_err` halts the channel with `err_cause` = 2 (bus error). After any error, `busy` stays low and `kick` is ignored until reset.
- R11: While `freeze` is high no new memory or peripheral request starts, and the state is kept. Lowering `freeze` resumes from the same point.
- R12: With bit 7 set, the descriptor's completion waits after its data phase until `per_end` is high.
- R13: Once raised, `mem_req` and `per_req` stay high until acknowledged, unless a termination aborts the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kick | input | 1 | Start pulse, accepted when idle |
| kick_ptr | input | 32 | Address of the first descriptor |
| sema_add | input | SEM_W | Amount added to the semaphore this cycle |
| freeze | input | 1 | Hold at the next word boundary |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_err | input | 1 | Error response, valid with `mem_ack` |
| pio_we | output | 1 | PIO register write strobe |
| pio_sel | output | 4 | PIO register slot |
| pio_data | output | 32 | PIO write data |
| per_req | output | 1 | Peripheral data request |
| per_we | output | 1 | Write to peripheral (1) or read from it (0) |
| per_wdata | output | 32 | Data to peripheral |
| per_rdata | input | 32 | Data from peripheral |
| per_ack | input | 1 | Peripheral acknowledge |
| per_term | input | 1 | Peripheral terminate request |
| per_end | input | 1 | Peripheral end-of-operation |
| busy | output | 1 | Channel active (including waiting on the semaphore) |
| irq | output | 1 | One-cycle completion pulse |
| err_cause | output | 2 | 0 none, 1 termination, 2 bus error |
| cur_addr | output | 32 | Current buffer address |
| sema_cnt | output | SEM_W | Semaphore count |

## Verification
Every result has a known delay from its cause. A PIO strobe appears one cycle after the memory acknowledge of its word. `irq` rises one cycle after the last data word or `per_end`. `err_cause` is set one cycle after the failing response or terminate. A request rises one cycle after the engine becomes able to issue it. The bench keeps queues of the expected PIO writes, peripheral writes and memory writes, and compares each transfer at the falling edge of the very cycle in which it is acknowledged. Status outputs are checked only after a settling window, once the pulses that could change them have passed.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    localparam int WORD_W   = 32;
    localparam int CNT_W    = 16;
    localparam int PIO_W    = 4;
    localparam int HDR_WORDS = 3;
    localparam int HDR_BYTES = HDR_WORDS * (WORD_W / 8);

    typedef enum logic [1:0] {
        CMD_NONE     = 2'd0,
        CMD_TO_MEM   = 2'd1,
        CMD_FROM_MEM = 2'd2,
        CMD_SENSE    = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_TERM = 2'd1,
        CAUSE_BUS  = 2'd2
    } cause_e;

    typedef enum logic [3:0] {
        S_IDLE, S_WSEM, S_FETCH, S_PIO, S_SRC, S_DST, S_WEND, S_DONE, S_HALT
    } state_e;

    // control half-word; bit positions are decoded by software-built descriptors
    typedef struct packed {
        logic [PIO_W-1:0] npio;      // 15:12
        logic [1:0]       spare;     // 11:10
        logic             flush;     // 9
        logic             halt_term; // 8
        logic             wait_end;  // 7
        logic             dec_sem;   // 6
        logic             rdy_wait;  // 5
        logic             lock;      // 4
        logic             irq;       // 3
        logic             chain;     // 2
        cmd_e             cmd;       // 1:0
    } ctl_t;

    function automatic logic moves_data(ctl_t c);
        return (c.cmd == CMD_TO_MEM) || (c.cmd == CMD_FROM_MEM);
    endfunction

    function automatic logic [CNT_W-1:0] word_count(logic [CNT_W-1:0] nbytes);
        logic [CNT_W:0] s;
        s = {1'b0, nbytes} + (CNT_W+1)'(3);
        return {1'b0, s[CNT_W:2]};
    endfunction

endpackage

// File: rtl/dmac_req.sv
module dmac_req (
    input  logic clk,
    input  logic rst,
    input  logic want,
    input  logic freeze,
    input  logic ack,
    output logic req,
    output logic done
);
    always_ff @(posedge clk) begin
        if (rst)
            req <= 1'b0;
        else if (req && (ack || !want))
            req <= 1'b0;
        else if (!req && want && !freeze)
            req <= 1'b1;
    end

    assign done = req && ack;
endmodule

// File: rtl/dmac_sema.sv
module dmac_sema #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] add,
    input  logic         dec,
    output logic [W-1:0] cnt
);
    logic [W:0] sum;

    always_comb begin
        sum = {1'b0, cnt} + {1'b0, add};
        if (dec && (sum != '0))
            sum = sum - (W+1)'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else
            cnt <= sum[W] ? '1 : sum[W-1:0];
    end
endmodule

// File: rtl/dmac_channel.sv
module dmac_channel
    import dmac_pkg::*;
#(
    parameter int SEM_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              kick,
    input  logic [WORD_W-1:0] kick_ptr,
    input  logic [SEM_W-1:0]  sema_add,
    input  logic              freeze,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    output logic              pio_we,
    output logic [PIO_W-1:0]  pio_sel,
    output logic [WORD_W-1:0] pio_data,
    output logic              per_req,
    output logic              per_we,
    output logic [WORD_W-1:0] per_wdata,
    input  logic [WORD_W-1:0] per_rdata,
    input  logic              per_ack,
    input  logic              per_term,
    input  logic              per_end,
    output logic              busy,
    output logic              irq,
    output logic [1:0]        err_cause,
    output logic [WORD_W-1:0] cur_addr,
    output logic [SEM_W-1:0]  sema_cnt
);
    localparam int NPORT = 2;
    localparam int P_MEM = 0;
    localparam int P_PER = 1;

    state_e            st, st_body, st_fin;
    ctl_t              ctl;
    cause_e            cause;
    logic [WORD_W-1:0] ptr, nxt, bar, hold_q, src_data;
    logic [CNT_W-1:0]  wleft;
    logic [PIO_W-1:0]  widx;
    logic              term_hit, sem_dec, mem_done, per_done, src_done;
    logic [NPORT-1:0]  want, ack, req, done;

    // request holders for the memory and peripheral sides
    assign ack[P_MEM] = mem_ack;
    assign ack[P_PER] = per_ack;
    for (genvar g = 0; g < NPORT; g++) begin : g_port
        dmac_req u_req (
            .clk    (clk),
            .rst    (rst),
            .want   (want[g]),
            .freeze (freeze),
            .ack    (ack[g]),
            .req    (req[g]),
            .done   (done[g])
        );
    end
    assign mem_req  = req[P_MEM];
    assign per_req  = req[P_PER];
    assign mem_done = done[P_MEM];
    assign per_done = done[P_PER];

    dmac_sema #(.W(SEM_W)) u_sema (
        .clk (clk),
        .rst (rst),
        .add (sema_add),
        .dec (sem_dec),
        .cnt (sema_cnt)
    );

    assign sem_dec  = (st == S_DONE) && ctl.dec_sem;
    assign term_hit = per_term && ctl.halt_term;
    assign src_done = mem_done || per_done;
    assign src_data = (ctl.cmd == CMD_FROM_MEM) ? mem_rdata : per_rdata;

    always_comb begin
        want[P_MEM] = (st == S_FETCH) || (st == S_PIO) ||
                      ((st == S_SRC) && (ctl.cmd == CMD_FROM_MEM)) ||
                      ((st == S_DST) && (ctl.cmd == CMD_TO_MEM));
        want[P_PER] = ((st == S_SRC) && (ctl.cmd == CMD_TO_MEM)) ||
                      ((st == S_DST) && (ctl.cmd == CMD_FROM_MEM));
        case (st)
            S_FETCH: mem_addr = ptr + (WORD_W'(widx) << 2);
            S_PIO:   mem_addr = ptr + WORD_W'(HDR_BYTES) + (WORD_W'(widx) << 2);
            default: mem_addr = bar;
        endcase
    end

    always_comb begin
        st_fin = ctl.wait_end ? S_WEND : S_DONE;
        if (moves_data(ctl) && (wleft != '0))
            st_body = S_SRC;
        else
            st_body = st_fin;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= S_IDLE;
            ptr      <= '0;
            nxt      <= '0;
            bar      <= '0;
            hold_q   <= '0;
            ctl      <= '0;
            wleft    <= '0;
            widx     <= '0;
            cause    <= CAUSE_NONE;
            pio_we   <= 1'b0;
            pio_sel  <= '0;
            pio_data <= '0;
            irq      <= 1'b0;
        end else begin
            pio_we <= 1'b0;
            irq    <= 1'b0;
            case (st)
                S_IDLE: if (kick) begin
                    ptr <= kick_ptr;
                    st  <= S_WSEM;
                end
                S_WSEM: if (sema_cnt != '0) begin
                    widx <= '0;
                    st   <= S_FETCH;
                end
                S_FETCH: if (mem_done) begin
                    if (mem_err) begin
                        cause <= CAUSE_BUS;
                        st    <= S_HALT;
                    end else begin
                        case (widx)
                            PIO_W'(0): nxt <= mem_rdata;
                            PIO_W'(1): begin
                                ctl   <= ctl_t'(mem_rdata[15:0]);
                                wleft <= word_count(mem_rdata[31:16]);
                            end
                            default:   bar <= mem_rdata;
                        endcase
                        if (widx == PIO_W'(HDR_WORDS - 1)) begin
                            widx <= '0;
                            st   <= (ctl.npio != '0) ? S_PIO : st_body;
                        end else begin
                            widx <= widx + PIO_W'(1);
                        end
                    end
                end
                S_PIO: if (mem_done) begin
                    if (mem_err) begin
                        cause <= CAUSE_BUS;
                        st    <= S_HALT;
                    end else begin
                        pio_we   <= 1'b1;
                        pio_sel  <= widx;
                        pio_data <= mem_rdata;
                        if (widx == ctl.npio - PIO_W'(1)) begin
                            widx <= '0;
                            st   <= st_body;
                        end else begin
                            widx <= widx + PIO_W'(1);
                        end
                    end
                end
                S_SRC: begin
                    if (mem_done && mem_err) begin
                        cause <= CAUSE_BUS;
                        st    <= S_HALT;
                    end else if (term_hit) begin
                        cause <= CAUSE_TERM;
                        st    <= S_HALT;
                    end else if (src_done) begin
                        hold_q <= src_data;
                        st     <= S_DST;
                    end
                end
                S_DST: begin
                    if (mem_done && mem_err) begin
                        cause <= CAUSE_BUS;
                        st    <= S_HALT;
                    end else if (src_done) begin
                        bar   <= bar + WORD_W'(4);
                        wleft <= wleft - CNT_W'(1);
                        if (wleft == CNT_W'(1)) begin
                            st <= st_fin;
                        end else if (term_hit) begin
                            cause <= CAUSE_TERM;
                            st    <= S_HALT;
                        end else begin
                            st <= S_SRC;
                        end
                    end else if (term_hit) begin
                        cause <= CAUSE_TERM;
                        st    <= S_HALT;
                    end
                end
                S_WEND: if (per_end) st <= S_DONE;
                S_DONE: begin
                    irq <= ctl.irq;
                    if (ctl.chain) begin
                        ptr <= nxt;
                        st  <= S_WSEM;
                    end else begin
                        st <= S_IDLE;
                    end
                end
                default: st <= S_HALT;
            endcase
        end
    end

    assign mem_we    = (st == S_DST);
    assign per_we    = (st == S_DST);
    assign mem_wdata = hold_q;
    assign per_wdata = hold_q;
    assign busy      = (st != S_IDLE) && (st != S_HALT);
    assign err_cause = cause;
    assign cur_addr  = bar;

endmodule

// File: rtl/dmac_channel_chk.sv
module dmac_channel_chk #(
    parameter int SEM_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             freeze,
    input logic             mem_req,
    input logic             mem_ack,
    input logic             mem_err,
    input logic             per_req,
    input logic             per_ack,
    input logic             per_term,
    input logic             busy,
    input logic             irq,
    input logic [1:0]       err_cause,
    input logic [SEM_W-1:0] sema_add,
    input logic [SEM_W-1:0] sema_cnt
);
    a_r13_mem_hold: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack && !per_term |=> mem_req);

    a_r13_per_hold: assert property (@(posedge clk) disable iff (rst)
        per_req && !per_ack && !per_term |=> per_req);

    a_r11_mem_frozen: assert property (@(posedge clk) disable iff (rst)
        freeze && !mem_req |=> !mem_req);

    a_r11_per_frozen: assert property (@(posedge clk) disable iff (rst)
        freeze && !per_req |=> !per_req);

    a_r5_irq_pulse: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    a_r5_sema_step: assert property (@(posedge clk) disable iff (rst)
        sema_add == '0 |=> (sema_cnt == $past(sema_cnt)) ||
                           (sema_cnt == $past(sema_cnt) - SEM_W'(1)));

    a_r10_bus_halt: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_ack && mem_err |=> err_cause == 2'd2);

    a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err_cause != 2'd0 |=> (err_cause == $past(err_cause)) && !busy);
endmodule

bind dmac_channel dmac_channel_chk #(.SEM_W(SEM_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .freeze    (freeze),
    .mem_req   (mem_req),
    .mem_ack   (mem_ack),
    .mem_err   (mem_err),
    .per_req   (per_req),
    .per_ack   (per_ack),
    .per_term  (per_term),
    .busy      (busy),
    .irq       (irq),
    .err_cause (err_cause),
    .sema_add  (sema_add),
    .sema_cnt  (sema_cnt)
);

// File: tb/sim_dmac_channel.sv
module sim_dmac_channel;
    logic        clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst = 1'b1;
    logic        kick = 1'b0;
    logic [31:0] kick_ptr = '0;
    logic [7:0]  sema_add = '0;
    logic        freeze = 1'b0;
    logic        mem_req, mem_we, mem_ack, mem_err;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        pio_we;
    logic [3:0]  pio_sel;
    logic [31:0] pio_data;
    logic        per_req, per_we, per_ack, per_term;
    logic        per_end = 1'b0;
    logic [31:0] per_wdata, per_rdata;
    logic        busy, irq;
    logic [1:0]  err_cause;
    logic [31:0] cur_addr;
    logic [7:0]  sema_cnt;

    dmac_channel u0 (
        .clk(clk), .rst(rst), .kick(kick), .kick_ptr(kick_ptr),
        .sema_add(sema_add), .freeze(freeze),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .mem_err(mem_err),
        .pio_we(pio_we), .pio_sel(pio_sel), .pio_data(pio_data),
        .per_req(per_req), .per_we(per_we), .per_wdata(per_wdata),
        .per_rdata(per_rdata), .per_ack(per_ack), .per_term(per_term),
        .per_end(per_end),
        .busy(busy), .irq(irq), .err_cause(err_cause),
        .cur_addr(cur_addr), .sema_cnt(sema_cnt)
    );

    // behavioural memory and peripheral
    logic [31:0] mem [0:255];
    logic        err_en = 1'b0;
    logic [31:0] err_addr = '0;
    logic        term_en = 1'b0;
    int          term_at = 0;
    logic        tb_clr = 1'b0;
    logic [31:0] per_seed = '0;
    logic [31:0] per_seq;
    int          per_wr_n;

    assign mem_ack   = mem_req;
    assign mem_rdata = mem[mem_addr[9:2]];
    assign mem_err   = mem_req && err_en && (mem_addr == err_addr);
    assign per_ack   = per_req;
    assign per_rdata = per_seq;
    assign per_term  = term_en && per_req && per_we && (per_wr_n == term_at);

    always @(posedge clk) begin
        if (tb_clr) begin
            per_seq  <= per_seed;
            per_wr_n <= 0;
        end else begin
            if (per_req && per_ack && !per_we) per_seq <= per_seq + 1;
            if (per_req && per_ack && per_we)  per_wr_n <= per_wr_n + 1;
        end
    end

    // expected-event queues and counters
    logic [35:0] exp_pio[$];
    logic [31:0] exp_per[$];
    logic [63:0] exp_mw[$];
    int n_chk = 0;
    int n_bad = 0;
    int irq_n = 0;

    function automatic void chk(input string req, input logic [63:0] act,
                                input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endfunction

    // event monitor, one comparison per transfer in the cycle it happens
    always @(negedge clk) begin
        if (tb_clr) irq_n = 0;
        else if (!rst) begin
            if (irq) irq_n++;
            if (pio_we) begin
                if (exp_pio.size() == 0) chk("R3 unexpected pio write", {28'b0, pio_sel, pio_data}, 0);
                else chk("R3 pio write", {28'b0, pio_sel, pio_data}, {28'b0, exp_pio.pop_front()});
            end
            if (per_req && per_ack && per_we) begin
                if (exp_pio.size() != 0) chk("R3 data before pio done", 1, 0);
                if (exp_per.size() == 0) chk("R4 unexpected peripheral write", per_wdata, 0);
                else chk("R4 peripheral write", per_wdata, exp_per.pop_front());
            end
            if (mem_req && mem_ack && mem_we && !mem_err) begin
                if (exp_mw.size() == 0) chk("R4 unexpected memory write", {mem_addr, mem_wdata}, 0);
                else chk("R4 memory write", {mem_addr, mem_wdata}, exp_mw.pop_front());
            end
        end
    end

    function automatic logic [15:0] cw(int cmd, int chain, int irqb, int dec,
                                       int w4e, int halt, int npio);
        return 16'(cmd & 3) | 16'(chain << 2) | 16'(irqb << 3) | 16'(dec << 6) |
               16'(w4e << 7) | 16'(halt << 8) | 16'((npio & 15) << 12);
    endfunction

    task automatic put_desc(int a, int nxt, logic [15:0] c, int cnt, int bufa, int npio, int pbase);
        mem[a >> 2]       = 32'(nxt);
        mem[(a >> 2) + 1] = {16'(cnt), c};
        mem[(a >> 2) + 2] = 32'(bufa);
        for (int i = 0; i < npio; i++) mem[(a >> 2) + 3 + i] = 32'(pbase + i);
    endtask

    task automatic settle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start(int seed);
        @(negedge clk);
        rst = 1'b1; kick = 1'b0; sema_add = '0; freeze = 1'b0; per_end = 1'b0;
        term_en = 1'b0; err_en = 1'b0; per_seed = 32'(seed); tb_clr = 1'b1;
        settle(3);
        rst = 1'b0; tb_clr = 1'b0;
        settle(1);
    endtask

    task automatic go(int ptr, int s);
        kick = 1'b1; kick_ptr = 32'(ptr); sema_add = 8'(s);
        @(negedge clk);
        kick = 1'b0; sema_add = '0;
    endtask

    task automatic wait_idle();
        int k = 0;
        while (busy && k < 3000) begin @(negedge clk); k++; end
        if (k >= 3000) chk("idle timeout", 0, 1);
        settle(3);
    endtask

    task automatic drained(string req);
        chk(req, exp_pio.size() + exp_per.size() + exp_mw.size(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h1111_0000 + 32'(i);
        // data words at 0x200.. hold 0x11110080 + k

        // R1 reset state
        start(0);
        chk("R1 busy", busy, 0); chk("R1 irq", irq, 0); chk("R1 err_cause", err_cause, 0);
        chk("R1 sema", sema_cnt, 0); chk("R1 mem_req", mem_req, 0);
        chk("R1 per_req", per_req, 0); chk("R1 pio_we", pio_we, 0);

        // R3 R5 R6 PIO-only descriptor, unchained: goes idle
        put_desc(32'h000, 0, cw(0, 0, 1, 1, 0, 0, 3), 0, 32'h300, 3, 32'hA0);
        start(0);
        for (int i = 0; i < 3; i++) exp_pio.push_back({4'(i), 32'hA0 + 32'(i)});
        go(32'h000, 1);
        wait_idle();
        drained("R3 pio words");
        chk("R5 irq count", irq_n, 1); chk("R5 sema decremented", sema_cnt, 0);
        chk("R6 unchained idle", busy, 0); chk("R8 no data moved", cur_addr, 32'h300);

        // R2 R4 R8 memory to peripheral with PIO first, count 10 -> 3 words
        put_desc(32'h040, 0, cw(2, 0, 1, 1, 0, 0, 2), 10, 32'h200, 2, 32'hB0);
        start(0);
        exp_pio.push_back({4'd0, 32'hB0}); exp_pio.push_back({4'd1, 32'hB1});
        for (int i = 0; i < 3; i++) exp_per.push_back(32'h1111_0080 + 32'(i));
        go(32'h040, 1);
        wait_idle();
        drained("R4 from memory");
        chk("R8 cur_addr", cur_addr, 32'h20C); chk("R2 irq", irq_n, 1);

        // R4 R5 peripheral to memory, no interrupt bit
        put_desc(32'h060, 0, cw(1, 0, 0, 1, 0, 0, 0), 6, 32'h280, 0, 0);
        start(32'h5000);
        exp_mw.push_back({32'h280, 32'h5000}); exp_mw.push_back({32'h284, 32'h5001});
        go(32'h060, 1);
        wait_idle();
        drained("R4 to memory");
        chk("R5 no irq without bit", irq_n, 0); chk("R8 cur_addr", cur_addr, 32'h288);

        // R4 R5 sense command moves nothing, no decrement bit keeps semaphore
        put_desc(32'h0E0, 0, cw(3, 0, 1, 0, 0, 0, 0), 8, 32'h240, 0, 0);
        start(0);
        go(32'h0E0, 1);
        wait_idle();
        drained("R4 sense no data");
        chk("R4 sense cur_addr", cur_addr, 32'h240); chk("R5 sema kept", sema_cnt, 1);

        // R6 R7 ring A -> B -> A gated by the semaphore
        put_desc(32'h080, 32'h0C0, cw(2, 1, 1, 1, 0, 0, 0), 4, 32'h200, 0, 0);
        put_desc(32'h0C0, 32'h080, cw(2, 1, 1, 1, 0, 0, 0), 4, 32'h204, 0, 0);
        start(0);
        go(32'h080, 0);
        settle(20);
        chk("R6 start waits on zero semaphore", busy, 1); drained("R6 nothing moved");
        exp_per.push_back(32'h1111_0080); exp_per.push_back(32'h1111_0081);
        sema_add = 8'd2; @(negedge clk); sema_add = '0;
        settle(60);
        drained("R7 two descriptors");
        chk("R7 parked busy", busy, 1); chk("R7 sema", sema_cnt, 0);
        chk("R7 irq count", irq_n, 2); chk("R7 no error", err_cause, 0);
        exp_per.push_back(32'h1111_0080);
        sema_add = 8'd1; @(negedge clk); sema_add = '0;
        settle(60);
        drained("R7 wrap to first"); chk("R7 irq count", irq_n, 3);

        // R11 freeze in the middle of a transfer
        put_desc(32'h100, 0, cw(2, 0, 1, 1, 0, 0, 0), 16, 32'h200, 0, 0);
        start(0);
        for (int i = 0; i < 4; i++) exp_per.push_back(32'h1111_0080 + 32'(i));
        go(32'h100, 1);
        begin
            int k = 0, bad = 0;
            logic [31:0] a;
            while (per_wr_n != 1 && k < 200) begin @(negedge clk); k++; end
            freeze = 1'b1;
            a = cur_addr;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (mem_req || per_req || cur_addr != a) bad++;
            end
            chk("R11 frozen activity", bad, 0); chk("R11 frozen address", a, 32'h204);
            freeze = 1'b0;
        end
        wait_idle();
        drained("R11 resumed"); chk("R11 final address", cur_addr, 32'h210);

        // R12 wait for end
        put_desc(32'h120, 0, cw(2, 0, 1, 1, 1, 0, 0), 4, 32'h200, 0, 0);
        start(0);
        exp_per.push_back(32'h1111_0080);
        go(32'h120, 1);
        settle(30);
        chk("R12 waits busy", busy, 1); chk("R12 no irq yet", irq_n, 0);
        per_end = 1'b1; @(negedge clk); per_end = 1'b0;
        settle(4);
        chk("R12 irq after end", irq_n, 1); chk("R12 idle", busy, 0);

        // R9 termination mid-descriptor halts
        put_desc(32'h160, 0, cw(2, 0, 1, 1, 0, 1, 0), 12, 32'h200, 0, 0);
        start(0);
        exp_per.push_back(32'h1111_0080); exp_per.push_back(32'h1111_0081);
        term_en = 1'b1; term_at = 1;
        go(32'h160, 1);
        settle(40);
        drained("R9 two words before terminate");
        chk("R9 cause termination", err_cause, 1); chk("R9 halted", busy, 0);
        chk("R9 address", cur_addr, 32'h208); chk("R9 no irq", irq_n, 0);

        // R9 termination on the last word is not an error
        start(0);
        for (int i = 0; i < 3; i++) exp_per.push_back(32'h1111_0080 + 32'(i));
        term_en = 1'b1; term_at = 2;
        go(32'h160, 1);
        wait_idle();
        drained("R9 last word");
        chk("R9 coincident no error", err_cause, 0); chk("R9 coincident irq", irq_n, 1);

        // R9 terminate ignored when halt bit is clear
        put_desc(32'h180, 0, cw(2, 0, 1, 1, 0, 0, 0), 12, 32'h200, 0, 0);
        start(0);
        for (int i = 0; i < 3; i++) exp_per.push_back(32'h1111_0080 + 32'(i));
        term_en = 1'b1; term_at = 0;
        go(32'h180, 1);
        wait_idle();
        drained("R9 ignored terminate"); chk("R9 ignored no error", err_cause, 0);

        // R10 bus error on the second PIO fetch, then kicks ignored
        put_desc(32'h1A0, 0, cw(0, 0, 1, 1, 0, 0, 2), 0, 32'h300, 2, 32'hC0);
        start(0);
        exp_pio.push_back({4'd0, 32'hC0});
        err_en = 1'b1; err_addr = 32'h1A0 + 32'd16;
        go(32'h1A0, 1);
        settle(30);
        drained("R10 pio before error");
        chk("R10 cause bus", err_cause, 2); chk("R10 halted", busy, 0);
        err_en = 1'b0;
        go(32'h000, 1);
        settle(30);
        drained("R10 kick ignored");
        chk("R10 still halted", busy, 0); chk("R10 cause kept", err_cause, 2);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule